// File: doc/BRIEF.md
# Bulk-IN Short-Packet Release and Wakeup Controller

This block sits beside a device-to-host transmit buffer. On each Bulk-IN request from the host it decides, one clock later, what goes out. A full packet of the maximum size goes out whenever enough bytes are waiting. An empty buffer produces a zero-length response. A partly filled buffer is held back until one of two things allows it to go out: a latency timer runs out, or the external strobe pin has asked for an immediate send.

The latency timer counts 1 ms ticks while data is waiting. It starts again after every byte written and after every release. Its limit is a register that reset sets to 16 ms and that software may set anywhere from 1 to 255 ms.

The active-low strobe pin is synchronised and edge-detected, and it has two meanings. While the bus is active, a falling edge arms a send-immediate that releases the remaining bytes on the next request. While the bus is suspended, a falling edge produces a one-cycle resume request, but only if remote wakeup is enabled.

Top module: `bulkin_flush_ctrl`

## Requirements
- R1: After reset, `rel_valid`, `rel_short`, `rel_count` and `resume_req` are 0, the timeout limit is 16 ticks and no send-immediate is armed.
- R2: A request with `fill_level >= max_pkt` (and fill nonzero) gives, on the next cycle, `rel_valid`=1, `rel_short`=0 and `rel_count`=`max_pkt`.
- R3: A request with `fill_level`=0 gives, on the next cycle, `rel_valid`=1, `rel_short`=1 and `rel_count`=0 (zero-length response). This also clears any armed send-immediate.
- R4: A request with 0 < `fill_level` < `max_pkt` gives `rel_valid`=0 on the next cycle unless the timer has expired or a send-immediate is armed.
- R5: When the timer has expired or a send-immediate is armed, such a partial request gives `rel_valid`=1, `rel_short`=1 and `rel_count`=`fill_level` on the next cycle.
- R6: The timer expires after as many `tick_1ms` pulses as the limit, counted while `fill_level` is nonzero. It returns to zero on a `byte_wr` pulse or on any release. It stays at zero while the buffer is empty.
- R7: A `tmo_we` pulse with `tmo_wdata` in 1..255 sets the limit. A write of 0 is ignored and the old limit stays.
- R8: A falling edge on `strobe_n` while `suspended`=0 arms a send-immediate, even if the low pulse lasts only one clock. The edge is seen 2 clocks after the pin falls (two-stage synchroniser). The send-immediate stays armed until a short or zero-length release.
- R9: A request in the same cycle in which a non-suspended strobe edge is detected already uses that edge, and leaves nothing armed afterwards.
- R10: A strobe falling edge while `suspended`=1 and `wake_en`=1 gives `resume_req`=1 for exactly one cycle, 3 cycles after the pin is driven low. It does not arm a send-immediate.
- R11: A strobe falling edge while `suspended`=1 and `wake_en`=0 is ignored: no `resume_req` and no send-immediate.
- R12: A full-packet release does not clear an armed send-immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | CNT_W (9) | Bytes waiting in the transmit buffer (0..384) |
| byte_wr | input | 1 | Pulse: one byte was written into the buffer |
| max_pkt | input | CNT_W (9) | Maximum packet size, at least 1 |
| in_req | input | 1 | Pulse: Bulk-IN request from the host |
| tick_1ms | input | 1 | Pulse once per millisecond |
| tmo_we | input | 1 | Write strobe for the timeout limit |
| tmo_wdata | input | TMO_W (8) | New timeout limit in ms |
| strobe_n | input | 1 | Asynchronous active-low send-immediate / wakeup pin |
| suspended | input | 1 | Bus is in suspend |
| wake_en | input | 1 | Remote wakeup enabled |
| rel_valid | output | 1 | Release decision valid for this request |
| rel_short | output | 1 | Released packet is short (includes zero-length) |
| rel_count | output | CNT_W (9) | Bytes released |
| resume_req | output | 1 | One-cycle resume request |

## Verification
Two functions can act in the same cycle: a strobe edge that has just been detected, and a Bulk-IN request that needs that edge to release a partial buffer. The bench drives the pin low two clocks before the request. The release must happen at once, and a second request right after must be held back, which shows the edge was used and not left armed. A second pair is a full-packet release while a send-immediate is armed. The bench checks that the 64-byte packet goes out and that the following partial request still releases its bytes. Sweeps over every fill level and over small timeout limits check the counts against arithmetic.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_FULL  = 2'd1,
    DEC_SHORT = 2'd2,
    DEC_ZLP   = 2'd3
  } rel_kind_e;
endpackage

// File: rtl/bfc_strobe_sync.sv
module bfc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/bfc_latency_timer.sv
module bfc_latency_timer #(
  parameter int TMO_W   = 8,
  parameter int DEF_TMO = 16,
  parameter int CNT_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic [CNT_W-1:0] fill_level,
  input  logic             tick,
  input  logic             restart,
  output logic             expired
);
  logic [TMO_W-1:0] limit_q;
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                           limit_q <= TMO_W'(DEF_TMO);
    else if (tmo_we && tmo_wdata != '0) limit_q <= tmo_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || fill_level == '0) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (cnt_next >= {1'b0, limit_q}) expired <= 1'b1;
      else                             cnt_q   <= cnt_next[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/bfc_release_arb.sv
module bfc_release_arb
  import bfc_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  input  logic [CNT_W-1:0] fill_level,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             flush_ok,
  output logic             fire,
  output logic             short_fire,
  output logic             rel_valid,
  output logic             rel_short,
  output logic [CNT_W-1:0] rel_count
);
  rel_kind_e kind;

  always_comb begin
    kind = DEC_NONE;
    if (in_req) begin
      if (fill_level == '0)           kind = DEC_ZLP;
      else if (fill_level >= max_pkt) kind = DEC_FULL;
      else if (flush_ok)              kind = DEC_SHORT;
    end
  end

  assign fire       = (kind != DEC_NONE);
  assign short_fire = (kind == DEC_SHORT) || (kind == DEC_ZLP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid <= 1'b0;
      rel_short <= 1'b0;
      rel_count <= '0;
    end else begin
      rel_valid <= fire;
      rel_short <= short_fire;
      case (kind)
        DEC_FULL:  rel_count <= max_pkt;
        DEC_SHORT: rel_count <= fill_level;
        default:   rel_count <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bulkin_flush_ctrl.sv
module bulkin_flush_ctrl #(
  parameter int BUF_DEPTH   = 384,
  parameter int TMO_W       = 8,
  parameter int DEF_TMO     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill_level,
  input  logic             byte_wr,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             in_req,
  input  logic             tick_1ms,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic             strobe_n,
  input  logic             suspended,
  input  logic             wake_en,
  output logic             rel_valid,
  output logic             rel_short,
  output logic [CNT_W-1:0] rel_count,
  output logic             resume_req
);
  logic fall;
  logic si_evt;
  logic si_pend;
  logic expired;
  logic fire;
  logic short_fire;

  bfc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (strobe_n),
    .fall  (fall)
  );

  assign si_evt = fall & ~suspended;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_pend    <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      si_pend    <= (si_pend | si_evt) & ~short_fire;
      resume_req <= fall & suspended & wake_en;
    end
  end

  bfc_latency_timer #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO), .CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .tmo_we     (tmo_we),
    .tmo_wdata  (tmo_wdata),
    .fill_level (fill_level),
    .tick       (tick_1ms),
    .restart    (byte_wr | fire),
    .expired    (expired)
  );

  bfc_release_arb #(.CNT_W(CNT_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .in_req     (in_req),
    .fill_level (fill_level),
    .max_pkt    (max_pkt),
    .flush_ok   (expired | si_pend | si_evt),
    .fire       (fire),
    .short_fire (short_fire),
    .rel_valid  (rel_valid),
    .rel_short  (rel_short),
    .rel_count  (rel_count)
  );
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fill_level,
  input logic [CNT_W-1:0] max_pkt,
  input logic             in_req,
  input logic             suspended,
  input logic             wake_en,
  input logic             rel_valid,
  input logic             rel_short,
  input logic [CNT_W-1:0] rel_count,
  input logic             resume_req
);
  a_r2_full_packet: assert property (@(posedge clk) disable iff (rst)
    (in_req && fill_level != '0 && fill_level >= max_pkt)
      |=> (rel_valid && !rel_short && rel_count == $past(max_pkt)));

  a_r3_zero_length: assert property (@(posedge clk) disable iff (rst)
    (in_req && fill_level == '0) |=> (rel_valid && rel_short && rel_count == '0));

  a_r5_short_count: assert property (@(posedge clk) disable iff (rst)
    (in_req && fill_level != '0 && fill_level < max_pkt)
      |=> (!rel_valid || (rel_short && rel_count == $past(fill_level))));

  a_r4_no_request_no_release: assert property (@(posedge clk) disable iff (rst)
    !in_req |=> !rel_valid);

  a_r11_resume_needs_enable: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> $past(suspended && wake_en));

  a_r10_resume_single: assert property (@(posedge clk) disable iff (rst)
    resume_req |=> !resume_req);
endmodule

bind bulkin_flush_ctrl bfc_checker #(.CNT_W(CNT_W)) u_bfc_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_level (fill_level),
  .max_pkt    (max_pkt),
  .in_req     (in_req),
  .suspended  (suspended),
  .wake_en    (wake_en),
  .rel_valid  (rel_valid),
  .rel_short  (rel_short),
  .rel_count  (rel_count),
  .resume_req (resume_req)
);

// File: tb/test_bulkin_flush_ctrl.sv
module test_bulkin_flush_ctrl;
  localparam int BUF = 384;
  localparam int CW  = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] fill_level = '0;
  logic          byte_wr = 1'b0;
  logic [CW-1:0] max_pkt = CW'(64);
  logic          in_req = 1'b0;
  logic          tick_1ms = 1'b0;
  logic          tmo_we = 1'b0;
  logic [7:0]    tmo_wdata = '0;
  logic          strobe_n = 1'b1;
  logic          suspended = 1'b0;
  logic          wake_en = 1'b0;
  logic          rel_valid, rel_short, resume_req;
  logic [CW-1:0] rel_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bulkin_flush_ctrl i_bulkin_flush_ctrl (
    .clk(clk), .rst(rst), .fill_level(fill_level), .byte_wr(byte_wr),
    .max_pkt(max_pkt), .in_req(in_req), .tick_1ms(tick_1ms),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .strobe_n(strobe_n),
    .suspended(suspended), .wake_en(wake_en), .rel_valid(rel_valid),
    .rel_short(rel_short), .rel_count(rel_count), .resume_req(resume_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start right after a negedge and end right after a negedge.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic req(input int f, input int ev, input int ec, input int es, input string tag);
    fill_level = CW'(f);
    in_req = 1'b1;
    @(negedge clk);
    in_req = 1'b0;
    chk({tag, " valid"}, int'(rel_valid), ev);
    if (ev != 0) begin
      chk({tag, " count"}, int'(rel_count), ec);
      chk({tag, " short"}, int'(rel_short), es);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
    end
  endtask

  task automatic wr_byte();
    byte_wr = 1'b1;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic set_tmo(input int v);
    tmo_wdata = 8'(v);
    tmo_we = 1'b1;
    @(negedge clk);
    tmo_we = 1'b0;
  endtask

  task automatic pulse_strobe();
    strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rel_valid", int'(rel_valid), 0);
    chk("R1 rel_short", int'(rel_short), 0);
    chk("R1 rel_count", int'(rel_count), 0);
    chk("R1 resume_req", int'(resume_req), 0);
    // R1 / R6: default limit of 16 ticks
    fill_level = CW'(10);
    wr_byte();
    tick(15);
    req(10, 0, 0, 0, "R1 default tmo 15 ticks");
    tick(1);
    req(10, 1, 10, 1, "R1 default tmo 16 ticks");

    // R2 R3 R4 sweep over every fill level, max_pkt 64
    max_pkt = CW'(64);
    wr_byte();
    for (int f = 0; f <= BUF; f++) begin
      if (f == 0)       req(f, 1, 0, 1, "R3 sweep empty");
      else if (f >= 64) req(f, 1, 64, 0, "R2 sweep full");
      else              req(f, 0, 0, 0, "R4 sweep partial");
    end
    // R2 R4 sweep over max_pkt with fill 32
    for (int m = 1; m <= 64; m++) begin
      max_pkt = CW'(m);
      if (m <= 32) req(32, 1, m, 0, "R2 max sweep");
      else         req(32, 0, 0, 0, "R4 max sweep");
    end
    max_pkt = CW'(64);

    // R5 R6 R7 timer sweep over small limits
    for (int t = 1; t <= 6; t++) begin
      set_tmo(t);
      fill_level = CW'(10);
      wr_byte();
      tick(t - 1);
      req(10, 0, 0, 0, "R6 before expiry");
      tick(1);
      req(10, 1, 10, 1, "R5 at expiry");
      req(10, 0, 0, 0, "R6 restart after release");
    end

    // R7 write of zero ignored
    set_tmo(3);
    set_tmo(0);
    fill_level = CW'(10);
    wr_byte();
    tick(2);
    req(10, 0, 0, 0, "R7 zero write ignored (2 ticks)");
    tick(1);
    req(10, 1, 10, 1, "R7 zero write ignored (3 ticks)");

    // R6 byte write restarts the count
    wr_byte();
    tick(2);
    wr_byte();
    tick(2);
    req(10, 0, 0, 0, "R6 byte restart");
    tick(1);
    req(10, 1, 10, 1, "R6 byte restart expiry");

    // R6 no counting while empty
    fill_level = '0;
    tick(5);
    fill_level = CW'(10);
    tick(2);
    req(10, 0, 0, 0, "R6 hold when empty");
    tick(1);
    req(10, 1, 10, 1, "R6 count after fill");

    // R8 send-immediate with one-clock pulse
    set_tmo(200);
    wr_byte();
    pulse_strobe();
    idle(4);
    req(20, 1, 20, 1, "R8 send-immediate release");
    req(20, 0, 0, 0, "R8 consumed");

    // R12 full release keeps send-immediate armed
    pulse_strobe();
    idle(4);
    req(100, 1, 64, 0, "R12 full while armed");
    req(20, 1, 20, 1, "R12 still armed");

    // R3 zero-length clears send-immediate
    pulse_strobe();
    idle(4);
    req(0, 1, 0, 1, "R3 zlp while armed");
    req(20, 0, 0, 0, "R3 zlp consumed");

    // R9 request in the same cycle as edge detection
    fill_level = CW'(30);
    pulse_strobe();
    idle(1);
    req(30, 1, 30, 1, "R9 same-cycle release");
    req(30, 0, 0, 0, "R9 nothing left armed");

    // R10 wakeup while suspended
    suspended = 1'b1;
    wake_en = 1'b1;
    pulse_strobe();
    chk("R10 resume k+1", int'(resume_req), 0);
    idle(1);
    chk("R10 resume k+2", int'(resume_req), 0);
    idle(1);
    chk("R10 resume k+3", int'(resume_req), 1);
    idle(1);
    chk("R10 resume k+4", int'(resume_req), 0);
    idle(2);
    suspended = 1'b0;
    req(20, 0, 0, 0, "R10 no send-immediate");

    // R11 ignored while suspended without wake enable
    suspended = 1'b1;
    wake_en = 1'b0;
    pulse_strobe();
    for (int i = 0; i < 5; i++) begin
      chk("R11 no resume", int'(resume_req), 0);
      idle(1);
    end
    suspended = 1'b0;
    req(20, 0, 0, 0, "R11 no send-immediate");

    finish_run();
  end
endmodule